// File: doc/BRIEF.md
# Lock-aware fully associative translation buffer

The block is a fully associative translation buffer of 64 entries, managed through register-style writes. Each entry pairs a tag with a 64-bit data word. Bit 63 of the data word marks the entry valid. Bit 6 pins the entry so that replacement and flush leave it alone.

Software first loads a staging tag register. It then stores a data word in one of two ways:

- **Automatic fill:** hardware picks the victim. It takes the lowest-numbered invalid entry. If every entry is valid, it takes the lowest-numbered unpinned entry. If every entry is valid and pinned, the write is dropped.
- **Indexed write:** the entry is named by address bits.

A combinational lookup reports whether a valid entry holds a presented tag. A flush input invalidates every unpinned entry. A combinational read port shows any entry by index.

Every write completes in the cycle it is presented. The victim search is a pair of combinational priority encoders, so there is no search state.

Top module: `xlat_buf`

## Requirements
- R1: After reset every entry's tag and data word are zero, the staging tag is zero, and every lookup misses.
- R2: Operation code 0 loads the staging tag from the low TAG_W bits of req_wdata_i and leaves all entries unchanged.
- R3: Operation code 1 (fill) writes the lowest-index entry whose data bit 63 is clear. The entry takes the staging tag and req_wdata_i, one clock after the request.
- R4: When no entry has bit 63 clear, a fill writes the lowest-index entry whose data bit 6 is clear.
- R5: When every entry has both bit 63 and bit 6 set, a fill changes no entry.
- R6: Operation code 2 (indexed write) writes the staging tag and req_wdata_i into the entry numbered by req_addr_i bits [IDX_LSB +: log2(NUM_ENTRIES)]. With the defaults these are bits 8:3. The write happens whatever that entry's valid and pin bits are.
- R7: lookup_hit_o is 1 exactly when some entry has bit 63 set and its tag equals lookup_tag_i. lookup_tag_o is then that tag; otherwise both outputs are zero.
- R8: flush_i clears bit 63 of every entry whose bit 6 is clear and keeps all other bits. Entries with bit 6 set are untouched. A request in the same cycle is dropped.
- R9: Operation code 3 changes neither the entries nor the staging tag.
- R10: rd_tag_o and rd_data_o show, combinationally, the entry numbered by rd_idx_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Invalidate all unpinned entries |
| req_op_i | input | 2 | 0 staging tag, 1 fill, 2 indexed write, 3 none |
| req_addr_i | input | ADDR_W | Address; selects the entry for an indexed write |
| req_wdata_i | input | DATA_W | Write value |
| lookup_tag_i | input | TAG_W | Tag to look up |
| lookup_hit_o | output | 1 | A valid entry holds lookup_tag_i |
| lookup_tag_o | output | TAG_W | Matching tag, or zero |
| rd_idx_i | input | IW | Entry to show on the read port |
| rd_tag_o | output | TAG_W | Tag of the selected entry |
| rd_data_o | output | DATA_W | Data word of the selected entry |

## Verification
The bench uses an eight-entry build. It fills the buffer from empty with pinned and unpinned entries interleaved, which shows that invalid slots are chosen first and in index order. It then fills the full buffer repeatedly and moves the pins, which separates the unpinned-victim pass from the invalid pass and shows the victim advancing as low entries become pinned. An all-pinned buffer, an indexed write that invalidates a middle entry, and a flush issued together with a fill expose the drop, the re-entry of the invalid pass and the flush priority. After every operation the bench compares all entries through the read port, and it runs lookup sweeps over present, absent and invalidated tags.

// File: rtl/xlat_buf_pkg.sv
package xlat_buf_pkg;
  typedef enum logic [1:0] {
    OP_TAGACC  = 2'd0,
    OP_FILL    = 2'd1,
    OP_INDEXED = 2'd2,
    OP_NONE    = 2'd3
  } xlat_op_e;
endpackage

// File: rtl/xlat_lowest_set.sv
module xlat_lowest_set #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // Scan downward so the lowest set bit is the last one written.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/xlat_store.sv
module xlat_store #(
  parameter int N         = 64,
  parameter int TAG_W     = 64,
  parameter int DATA_W    = 64,
  parameter int VALID_BIT = 63,
  parameter int LOCK_BIT  = 6
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic [N-1:0]                 we_i,
  input  logic [TAG_W-1:0]             wtag_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [N-1:0][TAG_W-1:0]      tag_o,
  output logic [N-1:0][DATA_W-1:0]     data_o
);
  for (genvar e = 0; e < N; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_o[e]  <= '0;
        data_o[e] <= '0;
      end else if (flush_i) begin
        if (!data_o[e][LOCK_BIT]) data_o[e][VALID_BIT] <= 1'b0;
      end else if (we_i[e]) begin
        tag_o[e]  <= wtag_i;
        data_o[e] <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/xlat_buf.sv
module xlat_buf
  import xlat_buf_pkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  parameter int TAG_W       = 64,
  parameter int DATA_W      = 64,
  parameter int ADDR_W      = 16,
  parameter int VALID_BIT   = 63,
  parameter int LOCK_BIT    = 6,
  parameter int IDX_LSB     = 3,
  localparam int IW         = $clog2(NUM_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [TAG_W-1:0]  lookup_tag_i,
  output logic              lookup_hit_o,
  output logic [TAG_W-1:0]  lookup_tag_o,
  input  logic [IW-1:0]     rd_idx_i,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o
);
  xlat_op_e op;
  logic [TAG_W-1:0] tag_acc_q;
  logic [NUM_ENTRIES-1:0][TAG_W-1:0]  tag_q;
  logic [NUM_ENTRIES-1:0][DATA_W-1:0] data_q;
  logic [NUM_ENTRIES-1:0] valid_vec, lock_vec, match_vec, we_vec;
  logic inv_found, unl_found, hit_found;
  logic [IW-1:0] inv_idx, unl_idx, hit_idx, victim_idx, wr_idx;
  logic tag_wr, fill_go, idx_go;

  assign op      = xlat_op_e'(req_op_i);
  assign tag_wr  = !flush_i && op == OP_TAGACC;
  assign fill_go = !flush_i && op == OP_FILL;
  assign idx_go  = !flush_i && op == OP_INDEXED;
  assign wr_idx  = req_addr_i[IDX_LSB +: IW];

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_vec
    assign valid_vec[i] = data_q[i][VALID_BIT];
    assign lock_vec[i]  = data_q[i][LOCK_BIT];
    assign match_vec[i] = valid_vec[i] && tag_q[i] == lookup_tag_i;
  end

  // First pass: invalid slots; second pass: unpinned slots.
  xlat_lowest_set #(.N(NUM_ENTRIES)) u_inv (
    .req_i(~valid_vec), .found_o(inv_found), .idx_o(inv_idx));
  xlat_lowest_set #(.N(NUM_ENTRIES)) u_unl (
    .req_i(~lock_vec), .found_o(unl_found), .idx_o(unl_idx));
  xlat_lowest_set #(.N(NUM_ENTRIES)) u_hit (
    .req_i(match_vec), .found_o(hit_found), .idx_o(hit_idx));

  assign victim_idx = inv_found ? inv_idx : unl_idx;

  always_comb begin
    we_vec = '0;
    if (fill_go && (inv_found || unl_found)) we_vec[victim_idx] = 1'b1;
    if (idx_go) we_vec[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tag_acc_q <= '0;
    else if (tag_wr) tag_acc_q <= req_wdata_i[TAG_W-1:0];
  end

  xlat_store #(
    .N(NUM_ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W),
    .VALID_BIT(VALID_BIT), .LOCK_BIT(LOCK_BIT)
  ) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i), .we_i(we_vec),
    .wtag_i(tag_acc_q), .wdata_i(req_wdata_i), .tag_o(tag_q), .data_o(data_q)
  );

  assign lookup_hit_o = hit_found;
  assign lookup_tag_o = hit_found ? tag_q[hit_idx] : '0;
  assign rd_tag_o     = tag_q[rd_idx_i];
  assign rd_data_o    = data_q[rd_idx_i];
endmodule

// File: rtl/xlat_buf_chk.sv
module xlat_buf_chk #(
  parameter int N         = 64,
  parameter int TAG_W     = 64,
  parameter int DATA_W    = 64,
  parameter int VALID_BIT = 63,
  parameter int IW        = 6
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     flush_i,
  input logic                     tag_wr,
  input logic                     fill_go,
  input logic                     idx_go,
  input logic                     nop,
  input logic [IW-1:0]            wr_idx,
  input logic [DATA_W-1:0]        wdata,
  input logic [TAG_W-1:0]         tag_acc_q,
  input logic [N-1:0][DATA_W-1:0] data_q,
  input logic [N-1:0]             valid_vec,
  input logic [N-1:0]             lock_vec,
  input logic                     lookup_hit_o,
  input logic [TAG_W-1:0]         lookup_tag_o
);
  // R2
  tag_acc_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_wr |=> tag_acc_q == $past(wdata[TAG_W-1:0]));
  // R3
  fill_grows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_go && !(&valid_vec) && wdata[VALID_BIT])
      |=> $countones(valid_vec) == $past($countones(valid_vec)) + 1);
  // R5
  full_locked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_go && (&valid_vec) && (&lock_vec)) |=> $stable(data_q));
  // R6
  idx_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_go |=> data_q[$past(wr_idx)] == $past(wdata));
  // R7
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_hit_o |-> lookup_tag_o == '0);
  // R8
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_vec & ~lock_vec) == '0);
  // R9
  nop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nop |=> $stable(data_q) && $stable(tag_acc_q));
endmodule

bind xlat_buf xlat_buf_chk #(
  .N(NUM_ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W),
  .VALID_BIT(VALID_BIT), .IW(IW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i), .tag_wr(tag_wr),
  .fill_go(fill_go), .idx_go(idx_go),
  .nop(!flush_i && req_op_i == 2'd3), .wr_idx(wr_idx),
  .wdata(req_wdata_i), .tag_acc_q(tag_acc_q), .data_q(data_q),
  .valid_vec(valid_vec), .lock_vec(lock_vec),
  .lookup_hit_o(lookup_hit_o), .lookup_tag_o(lookup_tag_o)
);

// File: tb/xlat_buf_test.sv
module xlat_buf_test;
  localparam int N = 8;
  localparam int TW = 16;
  localparam int DW = 64;
  localparam int AW = 16;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic flush_i = 1'b0;
  logic [1:0] req_op_i = 2'd3;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic [TW-1:0] lookup_tag_i = '0;
  logic lookup_hit_o;
  logic [TW-1:0] lookup_tag_o;
  logic [IW-1:0] rd_idx_i = '0;
  logic [TW-1:0] rd_tag_o;
  logic [DW-1:0] rd_data_o;

  int n_chk = 0, n_bad = 0;
  logic [TW-1:0] m_tag [N];
  logic [DW-1:0] m_data [N];
  logic [TW-1:0] m_tacc;

  always #10 clk = ~clk;

  xlat_buf #(.NUM_ENTRIES(N), .TAG_W(TW), .DATA_W(DW), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i), .req_op_i(req_op_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .lookup_tag_i(lookup_tag_i), .lookup_hit_o(lookup_hit_o),
    .lookup_tag_o(lookup_tag_o), .rd_idx_i(rd_idx_i), .rd_tag_o(rd_tag_o),
    .rd_data_o(rd_data_o));

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mk(input bit v, input bit l, input int p);
    logic [DW-1:0] d;
    d = DW'(p) << 8;
    d[63] = v;
    d[6] = l;
    return d;
  endfunction

  task automatic apply(input logic [1:0] op, input logic [AW-1:0] addr,
                       input logic [DW-1:0] wd, input bit fl);
    int vic;
    @(negedge clk);
    req_op_i = op; req_addr_i = addr; req_wdata_i = wd; flush_i = fl;
    @(negedge clk);
    req_op_i = 2'd3; flush_i = 1'b0;
    if (fl) begin
      for (int i = 0; i < N; i++) if (!m_data[i][6]) m_data[i][63] = 1'b0;
    end else if (op == 2'd0) m_tacc = wd[TW-1:0];
    else if (op == 2'd1) begin
      vic = -1;
      for (int i = N - 1; i >= 0; i--) if (!m_data[i][63]) vic = i;
      if (vic < 0) for (int i = N - 1; i >= 0; i--) if (!m_data[i][6]) vic = i;
      if (vic >= 0) begin m_tag[vic] = m_tacc; m_data[vic] = wd; end
    end else if (op == 2'd2) begin
      m_tag[addr[5:3]] = m_tacc; m_data[addr[5:3]] = wd;
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < N; i++) begin
      rd_idx_i = IW'(i);
      #1;
      chk(rd_tag_o == m_tag[i] && rd_data_o == m_data[i], req,
          {rd_tag_o, rd_data_o[47:0]}, {m_tag[i], m_data[i][47:0]});
    end
  endtask

  task automatic lookup(input logic [TW-1:0] t);
    bit h = 1'b0;
    for (int i = 0; i < N; i++) if (m_data[i][63] && m_tag[i] == t) h = 1'b1;
    lookup_tag_i = t;
    #1;
    chk(lookup_hit_o == h && lookup_tag_o == (h ? t : '0), "R7",
        {47'd0, lookup_hit_o, lookup_tag_o}, {47'd0, h, (h ? t : 16'd0)});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_tag[i] = '0; m_data[i] = '0; end
    m_tacc = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    check_all("R1 R10");
    lookup(16'h0000);
    apply(2'd0, '0, 64'h0000_0000_0000_A000, 1'b0);
    check_all("R2");
    // R3: empty buffer fills in index order, pins interleaved
    for (int k = 0; k < N; k++) begin
      apply(2'd0, '0, DW'(16'hA000 + k), 1'b0);
      apply(2'd1, '0, mk(1'b1, (k % 2) == 0, k * 37 + 5), 1'b0);
      check_all("R3");
    end
    for (int k = 0; k < N; k++) lookup(TW'(16'hA000 + k));
    lookup(16'hB000);
    // R4: full buffer, lowest unpinned victim
    apply(2'd0, '0, 64'hC001, 1'b0);
    apply(2'd1, '0, mk(1'b1, 1'b0, 91), 1'b0);
    check_all("R4");
    apply(2'd1, '0, mk(1'b1, 1'b1, 92), 1'b0);
    check_all("R4");
    apply(2'd1, '0, mk(1'b1, 1'b0, 93), 1'b0);
    check_all("R4");
    // R6: pin everything by index, staging tag varies
    for (int i = 0; i < N; i++) begin
      apply(2'd0, '0, DW'(16'hD000 + i), 1'b0);
      apply(2'd2, AW'(16'hFF00 | (i << 3) | 7), mk(1'b1, 1'b1, 200 + i), 1'b0);
    end
    check_all("R6");
    // R5: all valid and pinned, fill dropped
    apply(2'd1, '0, mk(1'b1, 1'b0, 300), 1'b0);
    check_all("R5");
    // R6 then R3: invalidate middle entry, fill returns there
    apply(2'd2, AW'((5 << 3) | 5), mk(1'b0, 1'b0, 301), 1'b0);
    check_all("R6");
    apply(2'd0, '0, 64'hE005, 1'b0);
    apply(2'd1, '0, mk(1'b1, 1'b0, 302), 1'b0);
    check_all("R3");
    lookup(16'hE005);
    // R8: unpin two entries, flush with concurrent fill
    apply(2'd2, AW'(2 << 3), mk(1'b1, 1'b0, 303), 1'b0);
    apply(2'd2, AW'(6 << 3), mk(1'b1, 1'b0, 304), 1'b0);
    apply(2'd1, '0, mk(1'b1, 1'b1, 305), 1'b1);
    check_all("R8");
    lookup(16'hE005);
    lookup(16'hD001);
    // R9: reserved code
    apply(2'd3, AW'(3 << 3), mk(1'b1, 1'b1, 306), 1'b0);
    check_all("R9");
    apply(2'd1, '0, mk(1'b1, 1'b0, 307), 1'b0);
    check_all("R9 R3");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule